// File: doc/BRIEF.md
# I2C Master SCL and Data Timing Engine

This block produces the clock waveform and the data change instants for an I2C master. It runs from a fast kernel clock and controls the two open-drain lines through output enables: a high enable pulls the line low, a low enable releases it. The two raw line levels come back in through a two-flop synchronizer and a digital glitch filter of programmable length. The clock phases are timed from the filtered level that the block sees on the line, not from its own drive. Because of this, a slave that holds the clock low stretches the low phase, and the filter and synchronizer latency are added to every phase.

Six fields set the timing: a prescaler, a low count, a high count, a setup count, a hold count and a filter length. All six are captured only while the block is disabled. In each low phase the block pulses a request, takes the next data bit, drives it onto the data line after the hold delay, and keeps the clock low until both the low count and the setup delay have run out. After each high phase it reports a completed bit. Framing, start and stop conditions and arbitration belong to the surrounding controller.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset and while `en` is low, `scl_oe`, `sda_oe`, `bit_req` and `bit_done` are 0. The six timing fields are captured on every clock while `en` is low and are held unchanged while `en` is high.
- R2: Each line input passes through two synchronizing flops and then a filter. The filtered output takes a new level only after the synchronized input has differed from it for max(F,1) consecutive clocks, where F is the filter field. `sda_rx` is the filtered data line, and a shorter low pulse leaves it at 1.
- R3: On the first clock edge that samples `en` high after a disabled period, `scl_oe` becomes 1.
- R4: While the clock line is driven low, the low count starts on the edge where the filtered clock line is first seen low. On that edge `tx_bit` is taken, and `bit_req` is 1 for exactly the following cycle.
- R5: `sda_oe` takes the inverse of the taken bit (1 drives a 0 onto the line) exactly H = HOLD*(P+1)+1 clocks after the low count starts, where P is the prescaler field.
- R6: `scl_oe` falls exactly max((LOW+1)*(P+1), H+(SETUP+1)*(P+1)) clocks after the low count starts.
- R7: After the line is released, the high count starts only on the edge where the filtered clock line reads 1, so holding the line low stretches the phase. (HIGH+1)*(P+1) clocks later, `scl_oe` rises and `bit_done` is 1 for exactly one cycle.
- R8: A clock edge that samples `en` low sets `scl_oe` and `sda_oe` to 0 and returns the block to idle.
- R9: While enabled, `sda_oe` changes only while `scl_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; fields are captured while low |
| presc | input | 4 | Prescaler field P, unit = P+1 clocks |
| scl_lo | input | 8 | Low count field LOW |
| scl_hi | input | 8 | High count field HIGH |
| setup_dly | input | 4 | Setup count field SETUP |
| hold_dly | input | 4 | Hold count field HOLD |
| flt_len | input | 4 | Glitch filter length F in clocks, 0 = off |
| tx_bit | input | 1 | Next data bit to place on the line |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| scl_oe | output | 1 | Clock line pull-down enable |
| sda_oe | output | 1 | Data line pull-down enable |
| bit_req | output | 1 | One-cycle pulse: data bit taken, present the next |
| bit_done | output | 1 | One-cycle pulse: a high phase completed |
| sda_rx | output | 1 | Filtered, synchronized data line level |

## Verification
The checks assume that `en` changes only on whole clock cycles. They also assume that `scl_in` is the wired-AND of the block's own release and an outside device's hold-low, so the clock line never reads high while the block drives it low. The bench builds both lines that way. It adds slave stretching and short data-line glitches only as extra low pulls on the released lines, and changes the fields while enabled only to confirm that they are ignored.

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer #(
  parameter int PRESC_W = 4,
  parameter int CNT_W   = 8,
  parameter int DEL_W   = 4,
  parameter int FLT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PRESC_W-1:0] presc,
  input  logic [CNT_W-1:0]   scl_lo,
  input  logic [CNT_W-1:0]   scl_hi,
  input  logic [DEL_W-1:0]   setup_dly,
  input  logic [DEL_W-1:0]   hold_dly,
  input  logic [FLT_W-1:0]   flt_len,
  input  logic               tx_bit,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               bit_req,
  output logic               bit_done,
  output logic               sda_rx
);
  localparam int TW = CNT_W + PRESC_W + 2;

  typedef enum logic [2:0] {IDLE, LSYNC, LOW, HSYNC, HIGH} st_t;
  st_t st;

  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   lo_q, hi_q;
  logic [DEL_W-1:0]   su_q, hd_q;
  logic [FLT_W-1:0]   flt_q;
  logic [TW-1:0]      cnt;
  logic               dbit;
  logic [1:0]         raw, flt;

  assign raw    = {sda_in, scl_in};
  assign sda_rx = flt[1];

  for (genvar i = 0; i < 2; i++) begin : g_flt
    logic s1, s2, f;
    logic [FLT_W-1:0] c;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1; s2 <= 1'b1; f <= 1'b1; c <= '0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        if (s2 == f) c <= '0;
        else if (flt_q == '0 || c == flt_q - FLT_W'(1)) begin
          f <= s2; c <= '0;
        end else c <= c + FLT_W'(1);
      end
    end
    assign flt[i] = f;
  end

  wire [TW-1:0] unit     = TW'(presc_q) + TW'(1);
  wire [TW-1:0] low_len  = (TW'(lo_q) + TW'(1)) * unit;
  wire [TW-1:0] high_len = (TW'(hi_q) + TW'(1)) * unit;
  wire [TW-1:0] hold_len = TW'(hd_q) * unit + TW'(1);
  wire [TW-1:0] su_end   = hold_len + (TW'(su_q) + TW'(1)) * unit;
  wire [TW-1:0] cnt_nx   = cnt + TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; dbit <= 1'b1;
      scl_oe <= 1'b0; sda_oe <= 1'b0; bit_req <= 1'b0; bit_done <= 1'b0;
      presc_q <= '0; lo_q <= '0; hi_q <= '0; su_q <= '0; hd_q <= '0; flt_q <= '0;
    end else begin
      bit_req  <= 1'b0;
      bit_done <= 1'b0;
      if (!en) begin
        st <= IDLE; cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
        presc_q <= presc; lo_q <= scl_lo; hi_q <= scl_hi;
        su_q <= setup_dly; hd_q <= hold_dly; flt_q <= flt_len;
      end else begin
        case (st)
          IDLE: begin
            st <= LSYNC; scl_oe <= 1'b1;
          end
          LSYNC: if (!flt[0]) begin
            st <= LOW; cnt <= '0; bit_req <= 1'b1; dbit <= tx_bit;
          end
          LOW: begin
            cnt <= cnt_nx;
            if (cnt_nx == hold_len) sda_oe <= ~dbit;
            if (cnt_nx >= low_len && cnt_nx >= su_end) begin
              st <= HSYNC; scl_oe <= 1'b0;
            end
          end
          HSYNC: if (flt[0]) begin
            st <= HIGH; cnt <= '0;
          end
          HIGH: begin
            cnt <= cnt_nx;
            if (cnt_nx >= high_len) begin
              st <= LSYNC; scl_oe <= 1'b1; bit_done <= 1'b1;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_bus_timer_chk.sv
module i2c_bus_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        bit_req,
  input logic        bit_done,
  input logic [31:0] cfg
);
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe && !bit_req && !bit_done));
  p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);
  p_done_with_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> $rose(scl_oe));
  p_req_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |-> scl_oe);
  p_req_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> !bit_req);
  p_data_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sda_oe)) |-> scl_oe);
  p_fields_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(cfg));
endmodule

bind i2c_bus_timer i2c_bus_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .bit_req(bit_req), .bit_done(bit_done),
  .cfg({presc_q, lo_q, hi_q, su_q, hd_q, flt_q})
);

// File: tb/sim_i2c_bus_timer.sv
module sim_i2c_bus_timer;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tx_bit = 1'b0;
  logic [3:0] presc = '0, setup_dly = '0, hold_dly = '0, flt_len = '0;
  logic [7:0] scl_lo = '0, scl_hi = '0;
  logic stretch = 1'b0, glitch = 1'b0;
  logic scl_oe, sda_oe, bit_req, bit_done, sda_rx;
  logic scl_in, sda_in;
  int total = 0, fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign scl_in = ~scl_oe & ~stretch;
  assign sda_in = ~sda_oe & ~glitch;

  always #5 clk = ~clk;

  i2c_bus_timer u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .scl_lo(scl_lo),
    .scl_hi(scl_hi), .setup_dly(setup_dly), .hold_dly(hold_dly),
    .flt_len(flt_len), .tx_bit(tx_bit), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bit_req(bit_req),
    .bit_done(bit_done), .sda_rx(sda_rx)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // behavioural reference model, stepped once per clock at the falling edge
  int m_s1[2], m_s2[2], m_f[2], m_c[2];
  int m_ph, m_t, m_bit, m_soe, m_doe, m_req, m_done;
  int c_p, c_lo, c_hi, c_su, c_hd, c_f;
  int prev_doe, prev_en;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_s1[i] = 1; m_s2[i] = 1; m_f[i] = 1; m_c[i] = 0; end
      m_ph = 0; m_t = 0; m_bit = 1; m_soe = 0; m_doe = 0; m_req = 0; m_done = 0;
      c_p = 0; c_lo = 0; c_hi = 0; c_su = 0; c_hd = 0; c_f = 0;
      prev_doe = 0; prev_en = 0;
    end else begin
      chk("R6", "scl_oe vs model", int'(scl_oe), m_soe);
      chk("R5", "sda_oe vs model", int'(sda_oe), m_doe);
      chk("R4", "bit_req vs model", int'(bit_req), m_req);
      chk("R7", "bit_done vs model", int'(bit_done), m_done);
      chk("R2", "sda_rx vs model", int'(sda_rx), m_f[1]);
      if (prev_en != 0 && en && int'(sda_oe) != prev_doe)
        chk("R9", "scl_oe while data moves", int'(scl_oe), 1);
      prev_doe = int'(sda_oe);
      prev_en = int'(en);
      begin
        int u, hold, su_end, low, high, raw[2], t_old;
        u = c_p + 1;
        hold = c_hd * u + 1;
        su_end = hold + (c_su + 1) * u;
        low = (c_lo + 1) * u;
        high = (c_hi + 1) * u;
        raw[0] = int'(scl_in); raw[1] = int'(sda_in);
        m_req = 0; m_done = 0;
        if (!en) begin
          m_ph = 0; m_t = 0; m_soe = 0; m_doe = 0;
        end else begin
          t_old = m_t;
          case (m_ph)
            0: begin m_ph = 1; m_soe = 1; end
            1: if (m_f[0] == 0) begin m_ph = 2; m_t = 0; m_req = 1; m_bit = int'(tx_bit); end
            2: begin
              m_t = t_old + 1;
              if (m_t == hold) m_doe = (m_bit == 0) ? 1 : 0;
              if (m_t >= low && m_t >= su_end) begin m_ph = 3; m_soe = 0; end
            end
            3: if (m_f[0] == 1) begin m_ph = 4; m_t = 0; end
            default: begin
              m_t = t_old + 1;
              if (m_t >= high) begin m_ph = 1; m_soe = 1; m_done = 1; end
            end
          endcase
        end
        for (int i = 0; i < 2; i++) begin
          if (m_s2[i] == m_f[i]) m_c[i] = 0;
          else if (c_f == 0 || m_c[i] == c_f - 1) begin m_f[i] = m_s2[i]; m_c[i] = 0; end
          else m_c[i] = m_c[i] + 1;
          m_s2[i] = m_s1[i];
          m_s1[i] = raw[i];
        end
        if (!en) begin
          c_p = int'(presc); c_lo = int'(scl_lo); c_hi = int'(scl_hi);
          c_su = int'(setup_dly); c_hd = int'(hold_dly); c_f = int'(flt_len);
        end
      end
    end
  end

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_bit = lfsr[0];
    end
  endtask

  task automatic cfg(input int p, input int lo, input int hi, input int su, input int hd, input int f);
    presc = 4'(p); scl_lo = 8'(lo); scl_hi = 8'(hi);
    setup_dly = 4'(su); hold_dly = 4'(hd); flt_len = 4'(f);
  endtask

  task automatic start_check;
    @(posedge clk); #1; en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R3", "scl_oe after enable", int'(scl_oe), 1);
  endtask

  task automatic stop_check;
    @(posedge clk); #1; en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8", "scl_oe after disable", int'(scl_oe), 0);
    chk("R8", "sda_oe after disable", int'(sda_oe), 0);
    run(3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "scl_oe reset", int'(scl_oe), 0);
    chk("R1", "sda_oe reset", int'(sda_oe), 0);
    chk("R1", "bit_req reset", int'(bit_req), 0);
    chk("R1", "bit_done reset", int'(bit_done), 0);
    chk("R2", "sda_rx reset", int'(sda_rx), 1);

    cfg(1, 3, 2, 1, 2, 2);
    run(2);
    start_check();
    run(300);
    cfg(0, 0, 0, 0, 0, 0);  // R1: ignored while enabled, model keeps old fields
    run(300);
    stop_check();

    cfg(0, 0, 0, 3, 5, 0);  // setup and hold dominate the low phase (R6)
    run(2);
    start_check();
    run(400);
    stop_check();

    cfg(3, 10, 5, 2, 1, 5);
    run(2);
    start_check();
    run(200);
    while (scl_oe !== 1'b0) run(1);
    stretch = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R7", "scl_oe during stretch", int'(scl_oe), 0);
      chk("R7", "bit_done during stretch", int'(bit_done), 0);
      @(posedge clk); #1;
    end
    stretch = 1'b0;
    run(400);
    stop_check();

    cfg(15, 255, 3, 15, 15, 3);
    run(2);
    start_check();
    run(5000);
    stop_check();

    cfg(0, 2, 1, 0, 0, 4);
    run(4);
    glitch = 1'b1; run(3); glitch = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R2", "short glitch rejected", int'(sda_rx), 1);
      @(posedge clk); #1;
    end
    glitch = 1'b1; run(7);
    @(negedge clk);
    chk("R2", "long low passed", int'(sda_rx), 0);
    @(posedge clk); #1; glitch = 1'b0;
    run(12);
    @(negedge clk);
    chk("R2", "return high passed", int'(sda_rx), 1);
    start_check();
    run(300);
    stop_check();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule